// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block decides, every clock, whether the processor core should leave its current flow to service an interrupt, and which one. It watches an active-low reset request, one non-maskable line and twelve maskable lines numbered 4 to 15. Each non-reset line is captured into a pending flag on its rising edge. A fixed priority then picks the winner among the qualified requests. The choice is reported as a one-cycle strobe with the interrupt number and the service fetch address.

Software reaches the block through a small write port with four register slots. Slot 0 holds the individual enables and the non-maskable enable bit. That bit can only be set by software and is cleared only by hardware. Slot 1 holds the global enable. Slot 2 clears pending flags. Slot 3 is reserved and writes to it do nothing. The pipeline supplies a branch-delay-slot flag that holds off the non-maskable interrupt. It also supplies a return pulse that restores the global enable saved when a maskable interrupt was taken.

Top module: `irq_arbiter`

## Requirements
- R1: Priority is fixed. A valid reset beats the non-maskable interrupt (number 1), which beats every maskable one. Among maskable interrupts the lowest number wins, so INT4 is highest and INT15 is lowest.
- R2: A 0-to-1 transition on nmi_i or irq_i sets that line's pending flag. A line held high does not set it again. The flag stays set until that interrupt is taken, or until a write to slot 2 with data bit n at 1 clears INTn (bit 1 clears the non-maskable flag). If a new edge and a clear arrive together, the edge wins.
- R3: rst_req_n is active-low. A reset counts only if the line was sampled low on at least RST_MIN (10) consecutive clocks before it is sampled high again. A shorter low pulse changes no state. No interrupt is taken on a clock where rst_req_n is sampled low.
- R4: On a valid reset, the non-maskable enable, the global enable, the saved global enable, all individual enables and all pending flags return to 0. Reset is taken with number 0 and fetch address 0, whatever the delay-slot flag says.
- R5: The non-maskable interrupt is taken only when its flag is pending, the non-maskable enable is 1 and dslot_i is 0. While dslot_i is 1 the interrupt stays pending.
- R6: Taking the non-maskable interrupt clears the non-maskable enable and its pending flag. A second one is therefore held off until software sets the enable again.
- R7: A write to slot 0 with data bit 0 at 1 sets the non-maskable enable. Bit 0 at 0 leaves it unchanged. Data bits 4 to 15 load the enables of INT4 to INT15. A hardware clear in the same cycle wins over a software set.
- R8: While the non-maskable enable is 0, no maskable interrupt is taken, whatever its enables are.
- R9: INTn is taken only when it is pending, its enable is 1, the global enable (slot 1, data bit 0) is 1 and the non-maskable enable is 1.
- R10: Taking a maskable interrupt clears its pending flag, saves the global enable and clears the global enable. A ret_en_i pulse copies the saved value back. In one cycle, a take wins over ret_en_i, and ret_en_i wins over a slot-1 write.
- R11: take_o is registered and lasts one cycle per decision. It is high on the cycle after the clock at which the request qualified, so it appears two clocks after the edge on the line is first sampled. take_num_o carries the number and fetch_addr_o carries the number times 32; both are 0 when take_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req_n | input | 1 | Reset request line, active low, qualified by hold time |
| nmi_i | input | 1 | Non-maskable interrupt line, active high |
| irq_i | input | 12 | Maskable lines; bit k is INT(k+4) |
| dslot_i | input | 1 | Pipeline is in a branch delay slot |
| ret_en_i | input | 1 | Return pulse that restores the saved global enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register slot select |
| wr_data_i | input | 16 | Register write data |
| take_o | output | 1 | One-cycle strobe: service the selected interrupt |
| take_num_o | output | 5 | Number of the taken interrupt (0 reset, 1 NMI, 4..15) |
| fetch_addr_o | output | 10 | Service fetch address, number times 32 |

## Verification
The bench drives simultaneous edges on several maskable lines to check the winner order; a reversed or off-by-one encoder would name the wrong line or fetch from the wrong address. It holds the non-maskable request inside a delay slot and raises it while its enable is clear, where a missing gate would take it early or twice. It writes 0 to the enable bit and expects the block to stay blocked; a block that let software clear or toggle the bit would differ there. Reset low pulses of 9 and 12 cycles separate a correct hold counter from one that is off by one. A level held high after service must not re-trigger, and a design that captured levels instead of edges would take it again.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned NUM_W = 5;
  typedef logic [NUM_W-1:0] irq_num_t;

  localparam irq_num_t NUM_RESET = 5'd0;
  localparam irq_num_t NUM_NMI   = 5'd1;

  typedef enum logic [1:0] {
    SLOT_ENABLE = 2'd0,
    SLOT_GIE    = 2'd1,
    SLOT_PCLR   = 2'd2,
    SLOT_RSVD   = 2'd3
  } slot_e;

  // Service fetch address: interrupt number scaled by the vector spacing.
  function automatic logic [15:0] svc_addr(irq_num_t n, int unsigned shift);
    return 16'(n) << shift;
  endfunction

  // Interrupt number of a maskable line given its index in the vector.
  function automatic irq_num_t mask_num(int unsigned first, int unsigned idx);
    return irq_num_t'(first + idx);
  endfunction

endpackage

// File: rtl/irq_rst_qual.sv
module irq_rst_qual #(
  parameter int unsigned MIN_LOW = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req_n_i,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_q <= '0;
    end else if (!req_n_i) begin
      if (low_q != CW'(MIN_LOW)) low_q <= low_q + 1'b1;
    end else begin
      low_q <= '0;
    end
  end

  // Release edge after a long enough low period.
  assign valid_o = req_n_i && (low_q == CW'(MIN_LOW));
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] lines_i,
  input  logic [W-1:0] clr_i,
  input  logic         flush_i,
  output logic [W-1:0] pend_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic prev_q;
      logic pend_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= lines_i[g];
          if (flush_i)                     pend_q <= 1'b0;
          else if (lines_i[g] && !prev_q)  pend_q <= 1'b1;
          else if (clr_i[g])               pend_q <= 1'b0;
        end
      end
      assign pend_o[g] = pend_q;
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned W     = 12,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req_i,
  output logic             hit_o,
  output logic [W-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign hit_o = |req_i;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NUM_MASK   = 12,
  parameter int unsigned FIRST_MASK = 4,
  parameter int unsigned RST_MIN    = 10,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned VEC_SHIFT  = 5,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                rst_req_n,
  input  logic                nmi_i,
  input  logic [NUM_MASK-1:0] irq_i,
  input  logic                dslot_i,
  input  logic                ret_en_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                take_o,
  output logic [NUM_W-1:0]    take_num_o,
  output logic [ADDR_W-1:0]   fetch_addr_o
);
  localparam int unsigned IDX_W    = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1;
  localparam int unsigned LINES    = FIRST_MASK + NUM_MASK;
  localparam int unsigned NMI_BIT  = 1;
  localparam int unsigned NMIE_BIT = 0;
  localparam int unsigned GIE_BIT  = 0;

  // ---------------- register write decode ----------------
  slot_e wr_slot;
  logic  wr_enable_w, wr_gie_w, wr_pclr_w;
  assign wr_slot     = slot_e'(wr_addr_i);
  assign wr_enable_w = wr_en_i && (wr_slot == SLOT_ENABLE);
  assign wr_gie_w    = wr_en_i && (wr_slot == SLOT_GIE);
  assign wr_pclr_w   = wr_en_i && (wr_slot == SLOT_PCLR);

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[DATA_W-1:LINES], wr_data_i[FIRST_MASK-1:2]};

  // ---------------- control state ----------------
  logic                nmie_q;
  logic                gie_q;
  logic                pgie_q;
  logic [NUM_MASK-1:0] ien_q;

  // ---------------- named internal events ----------------
  logic                rst_valid_w;
  logic                nmi_pend;
  logic [NUM_MASK-1:0] mask_pend;
  logic                nmi_ok_w;
  logic [NUM_MASK-1:0] mask_qual_w;
  logic                mask_hit_w;
  logic [NUM_MASK-1:0] mask_grant_w;
  logic [IDX_W-1:0]    mask_idx_w;
  logic                take_nmi_w;
  logic                take_mask_w;

  irq_rst_qual #(.MIN_LOW(RST_MIN)) u_rst_qual (
    .clk     (clk),
    .arst_n  (arst_n),
    .req_n_i (rst_req_n),
    .valid_o (rst_valid_w)
  );

  logic [0:0] nmi_clr_w;
  logic [0:0] nmi_pend_v;
  assign nmi_clr_w[0] = take_nmi_w || (wr_pclr_w && wr_data_i[NMI_BIT]);

  irq_edge_pend #(.W(1)) u_nmi_pend (
    .clk     (clk),
    .arst_n  (arst_n),
    .lines_i (nmi_i),
    .clr_i   (nmi_clr_w),
    .flush_i (rst_valid_w),
    .pend_o  (nmi_pend_v)
  );
  assign nmi_pend = nmi_pend_v[0];

  logic [NUM_MASK-1:0] mask_clr_w;
  assign mask_clr_w = (take_mask_w ? mask_grant_w : '0)
                    | (wr_pclr_w ? wr_data_i[FIRST_MASK +: NUM_MASK] : '0);

  irq_edge_pend #(.W(NUM_MASK)) u_mask_pend (
    .clk     (clk),
    .arst_n  (arst_n),
    .lines_i (irq_i),
    .clr_i   (mask_clr_w),
    .flush_i (rst_valid_w),
    .pend_o  (mask_pend)
  );

  // ---------------- qualification ----------------
  assign nmi_ok_w    = nmi_pend && nmie_q && !dslot_i && rst_req_n;
  assign mask_qual_w = mask_pend & ien_q & {NUM_MASK{gie_q && nmie_q && rst_req_n}};

  irq_prio_pick #(.W(NUM_MASK), .IDX_W(IDX_W)) u_pick (
    .req_i   (mask_qual_w),
    .hit_o   (mask_hit_w),
    .grant_o (mask_grant_w),
    .idx_o   (mask_idx_w)
  );

  assign take_nmi_w  = !rst_valid_w && nmi_ok_w;
  assign take_mask_w = !rst_valid_w && !nmi_ok_w && mask_hit_w;

  // ---------------- enable registers ----------------
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      nmie_q <= 1'b0;
    end else if (rst_valid_w || take_nmi_w) begin
      nmie_q <= 1'b0;
    end else if (wr_enable_w && wr_data_i[NMIE_BIT]) begin
      nmie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ien_q <= '0;
    end else if (rst_valid_w) begin
      ien_q <= '0;
    end else if (wr_enable_w) begin
      ien_q <= wr_data_i[FIRST_MASK +: NUM_MASK];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else if (rst_valid_w) begin
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else if (take_mask_w) begin
      pgie_q <= gie_q;
      gie_q  <= 1'b0;
    end else if (ret_en_i) begin
      gie_q  <= pgie_q;
    end else if (wr_gie_w) begin
      gie_q  <= wr_data_i[GIE_BIT];
    end
  end

  // ---------------- registered decision ----------------
  irq_num_t    num_d;
  logic [15:0] addr_full_d;

  always_comb begin
    if (rst_valid_w)      num_d = NUM_RESET;
    else if (take_nmi_w)  num_d = NUM_NMI;
    else if (take_mask_w) num_d = mask_num(FIRST_MASK, int'(mask_idx_w));
    else                  num_d = '0;
  end

  assign addr_full_d = svc_addr(num_d, VEC_SHIFT);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      take_o       <= 1'b0;
      take_num_o   <= '0;
      fetch_addr_o <= '0;
    end else begin
      take_o       <= rst_valid_w || take_nmi_w || take_mask_w;
      take_num_o   <= num_d;
      fetch_addr_o <= addr_full_d[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
#(
  parameter int unsigned NUM_MASK   = 12,
  parameter int unsigned FIRST_MASK = 4,
  parameter int unsigned RST_MIN    = 10
) (
  input logic                clk,
  input logic                arst_n,
  input logic                rst_req_n,
  input logic                dslot_i,
  input logic                take_o,
  input logic [NUM_W-1:0]    take_num_o,
  input logic                rst_valid_w,
  input logic                nmie_q,
  input logic                gie_q,
  input logic [NUM_MASK-1:0] ien_q,
  input logic                nmi_pend,
  input logic [NUM_MASK-1:0] mask_pend
);
  localparam int unsigned CW = $clog2(RST_MIN + 1);

  // Independent count of consecutive low samples on the reset request.
  logic [CW-1:0] seen_low;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             seen_low <= '0;
    else if (rst_req_n)      seen_low <= '0;
    else if (seen_low < CW'(RST_MIN)) seen_low <= seen_low + 1'b1;
  end

  logic is_nmi, is_mask, is_rst;
  assign is_rst  = take_o && (take_num_o == NUM_RESET);
  assign is_nmi  = take_o && (take_num_o == NUM_NMI);
  assign is_mask = take_o && (take_num_o >= NUM_W'(FIRST_MASK));

  // R3: a qualified reset needs the full low hold
  a_r3_hold_met: assert property (@(posedge clk) disable iff (!arst_n)
    rst_valid_w |-> (seen_low >= CW'(RST_MIN)));

  // R3: nothing taken while the reset request is low
  a_r3_quiet_low: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_req_n |=> !take_o);

  // R4: reset service leaves every register at its default
  a_r4_defaults: assert property (@(posedge clk) disable iff (!arst_n)
    is_rst |-> (!nmie_q && !gie_q && ien_q == '0 && !nmi_pend && mask_pend == '0));

  // R5: non-maskable take needs the enable and no delay slot
  a_r5_nmi_gate: assert property (@(posedge clk) disable iff (!arst_n)
    is_nmi |-> ($past(nmie_q) && !$past(dslot_i)));

  // R6: non-maskable take leaves the enable cleared
  a_r6_nmie_cleared: assert property (@(posedge clk) disable iff (!arst_n)
    is_nmi |-> !nmie_q);

  // R8: maskable takes only happen with the non-maskable enable set
  a_r8_nmie_gates_mask: assert property (@(posedge clk) disable iff (!arst_n)
    is_mask |-> ($past(nmie_q) && $past(gie_q)));

  // R10: maskable take clears the global enable
  a_r10_gie_cleared: assert property (@(posedge clk) disable iff (!arst_n)
    is_mask |-> !gie_q);
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_MASK   (NUM_MASK),
  .FIRST_MASK (FIRST_MASK),
  .RST_MIN    (RST_MIN)
) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .rst_req_n   (rst_req_n),
  .dslot_i     (dslot_i),
  .take_o      (take_o),
  .take_num_o  (take_num_o),
  .rst_valid_w (rst_valid_w),
  .nmie_q      (nmie_q),
  .gie_q       (gie_q),
  .ien_q       (ien_q),
  .nmi_pend    (nmi_pend),
  .mask_pend   (mask_pend)
);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/100ps
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        rst_req_n = 1'b1;
  logic        nmi = 1'b0;
  logic [11:0] irq = '0;
  logic        dslot = 1'b0;
  logic        ret_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        take;
  logic [4:0]  num;
  logic [9:0]  faddr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .arst_n(arst_n), .rst_req_n(rst_req_n), .nmi_i(nmi),
    .irq_i(irq), .dslot_i(dslot), .ret_en_i(ret_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .take_o(take),
    .take_num_o(num), .fetch_addr_o(faddr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference, one update per clock ----------------
  int m_pend[16], m_en[16], m_prev[16];
  int m_nmie, m_gie, m_pgie, m_low;
  int e_take, e_num;

  always @(posedge clk) begin
    int win, old_gie;
    bit rv;
    logic [15:0] ln;
    if (!arst_n) begin
      for (int k = 0; k < 16; k++) begin m_pend[k] = 0; m_en[k] = 0; m_prev[k] = 0; end
      m_nmie = 0; m_gie = 0; m_pgie = 0; m_low = 0; e_take = 0; e_num = 0;
    end else begin
      ln = {irq, 2'b00, nmi, 1'b0};
      rv = rst_req_n && (m_low >= 10);
      if (!rst_req_n) m_low = (m_low < 10) ? m_low + 1 : m_low;
      else            m_low = 0;
      win = -1;
      if (rv) win = 0;
      else if (rst_req_n) begin
        if (m_pend[1] != 0 && m_nmie != 0 && !dslot) win = 1;
        else if (m_gie != 0 && m_nmie != 0)
          for (int k = 4; k < 16; k++)
            if (win < 0 && m_pend[k] != 0 && m_en[k] != 0) win = k;
      end
      old_gie = m_gie;
      if (rv) begin
        for (int k = 0; k < 16; k++) begin m_pend[k] = 0; m_en[k] = 0; end
        m_nmie = 0; m_gie = 0; m_pgie = 0;
      end else begin
        if (wr_en && wr_addr == 2'd0)
          for (int k = 4; k < 16; k++) m_en[k] = wr_data[k];
        if (win == 1) m_nmie = 0;
        else if (wr_en && wr_addr == 2'd0 && wr_data[0]) m_nmie = 1;
        if (win >= 4) begin m_pgie = old_gie; m_gie = 0; end
        else if (ret_en) m_gie = m_pgie;
        else if (wr_en && wr_addr == 2'd1) m_gie = wr_data[0];
        for (int k = 1; k < 16; k++) begin
          if (k == 2 || k == 3) continue;
          if (ln[k] && m_prev[k] == 0) m_pend[k] = 1;
          else if (k == win || (wr_en && wr_addr == 2'd2 && wr_data[k])) m_pend[k] = 0;
        end
      end
      for (int k = 0; k < 16; k++) m_prev[k] = ln[k];
      e_take = (win >= 0);
      e_num  = (win < 0) ? 0 : win;
    end
    #1;
    if (arst_n && model_on) begin
      string tg;
      tg = (e_take == 0) ? "R1" : (e_num == 0) ? "R4" : (e_num == 1) ? "R5" : "R9";
      check(take == e_take[0], tg, "model take", take, e_take);
      check(num == e_num[4:0], tg, "model number", num, e_num);
      check(faddr == 10'(e_num * 32), "R11", "model address", faddr, e_num * 32);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq(input logic [11:0] m);
    irq = irq | m; step(1); irq = irq & ~m;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1; step(1); nmi = 1'b0;
  endtask

  task automatic wait_take(input int exp, input string tag);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 6 && !got; i++) begin
      step(1);
      if (take) got = 1'b1;
    end
    check(got, tag, "take seen", got, 1);
    if (got) begin
      check(num == exp[4:0], tag, "taken number", num, exp);
      check(faddr == 10'(exp << 5), "R11", "fetch address", faddr, exp << 5);
      step(1);
      check(!take, "R11", "strobe one cycle", take, 0);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin step(1); if (take) seen = 1'b1; end
    check(!seen, tag, "no take", seen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R11: watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    arst_n = 1'b1;
    model_on = 1'b1;
    step(1);
    // R11: reset state
    check(!take && num == 0 && faddr == 0, "R11", "idle after reset", take, 0);
    quiet(3, "R11");

    // R1 R9: two lines together, lower number wins
    wr(2'd0, 16'hFFF1);
    wr(2'd1, 16'h0001);
    pulse_irq(12'b0000_0000_1010);        // INT5 and INT7
    wait_take(5, "R1");
    quiet(4, "R10");                      // global enable cleared by the take
    ret_en = 1'b1; step(1); ret_en = 1'b0;
    wait_take(7, "R10");

    // R2: level held high fires once only
    irq[2] = 1'b1;                        // INT6 held
    ret_en = 1'b1; step(1); ret_en = 1'b0;
    wait_take(6, "R2");
    ret_en = 1'b1; step(1); ret_en = 1'b0;
    quiet(5, "R2");
    irq[2] = 1'b0;

    // R5: delay slot holds off the non-maskable interrupt
    dslot = 1'b1;
    pulse_nmi();
    quiet(4, "R5");
    dslot = 1'b0;
    wait_take(1, "R5");
    // R8: enable now clear, maskable line blocked
    pulse_irq(12'b0000_0000_0001);        // INT4
    quiet(4, "R8");
    // R6: second non-maskable request blocked
    pulse_nmi();
    quiet(4, "R6");
    // R7: writing 0 to the enable bit changes nothing
    wr(2'd0, 16'hFFF0);
    quiet(4, "R7");
    wr(2'd0, 16'hFFF1);
    wait_take(1, "R1");                   // beats pending INT4
    wr(2'd0, 16'hFFF1);
    wait_take(4, "R8");

    // R2: software clear removes a pending flag
    pulse_irq(12'b0000_0010_0000);        // INT9, global enable is 0 here
    wr(2'd2, 16'h0200);
    wr(2'd1, 16'h0001);
    quiet(5, "R2");

    // R9: individual enable masks INT11, INT12 taken
    wr(2'd0, 16'h1001);
    pulse_irq(12'b0001_1000_0000);        // INT11 and INT12
    wait_take(12, "R9");
    quiet(4, "R9");

    // R3: short low pulse has no effect, no takes while low
    rst_req_n = 1'b0;
    wr(2'd0, 16'h0801);
    wr(2'd1, 16'h0001);
    quiet(7, "R3");
    rst_req_n = 1'b1;
    wait_take(11, "R3");

    // R4: valid reset inside a delay slot
    dslot = 1'b1;
    rst_req_n = 1'b0;
    step(12);
    rst_req_n = 1'b1;
    wait_take(0, "R4");
    dslot = 1'b0;
    wr(2'd0, 16'hFFF0);
    wr(2'd1, 16'h0001);
    pulse_irq(12'b0000_0000_0001);
    quiet(4, "R4");                       // enable bit came back at 0
    wr(2'd0, 16'hFFF1);
    wait_take(4, "R4");

    step(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule